// File: doc/BRIEF.md
# Maskable Alarm Comparator with Sticky Flag

This block watches a running BCD calendar (second, minute, hour, day of month and weekday) and raises an alarm when that calendar agrees with a programmed alarm setting. Software programs five alarm registers, one per calendar field. The top bit of each register is a disable bit: when it is set, that field takes no part in the comparison. The timekeeping counters are outside the block. They supply the current BCD values and a one-cycle pulse once per second.

The comparison runs only on the once-per-second pulse. The block sets a sticky alarm flag when every field that takes part in the comparison agrees with the calendar. The flag stays set until software writes a zero to it. An interrupt-enable bit lives in the same control register as the flag. When the flag and the enable are both set, an active-low interrupt line is held low. Register contents are read back through a registered read port.

Top module: `alarm_cmp`

## Requirements
- R1: After reset, every alarm register reads 0x80, the control register reads 0x00, the flag output is 0 and the interrupt output is 1.
- R2: The alarm registers sit at addresses 0x0B (second), 0x0C (minute), 0x0D (hour), 0x0E (day of month) and 0x0F (weekday), and all 8 written bits read back. The control register is at 0x01: bit 7 is the interrupt enable, bit 6 is the flag, and bits 5..0 read 0. Any other address reads 0x00. Read data appears one cycle after the read address.
- R3: Bit 7 = 1 in an alarm register removes that field from the comparison. An included field compares its low bits with the calendar value: 7 bits for second and minute, 6 bits for hour and day of month, and 3 bits for weekday.
- R4: On a clock edge where the second pulse is high and every included field agrees with the calendar, the flag is 1 from the next cycle on.
- R5: Without the second pulse, a matching calendar does not set the flag.
- R6: When all five fields are excluded, the flag never sets.
- R7: The flag stays set until a control write with bit 6 = 0. A control write with bit 6 = 1 leaves the flag unchanged.
- R8: When a flag-clearing control write and a flag-setting match fall on the same edge, the flag ends up set.
- R9: The interrupt output is 0 exactly when the flag and the enable are both 1. It changes in the same cycle as the flag and the enable.
- R10: Bit 7 of each control write sets the interrupt enable, and the enable reads back in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Registered read data |
| tick_i | input | 1 | Once-per-second pulse, one clock wide |
| sec_i | input | 7 | Current second, BCD |
| min_i | input | 7 | Current minute, BCD |
| hour_i | input | 6 | Current hour, BCD |
| mday_i | input | 6 | Current day of month, BCD |
| wday_i | input | 3 | Current weekday, 0..6 |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| irq_n_o | output | 1 | Active-low alarm interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, the control register at 0x01 and the alarm bank at 0x0B. With these values the whole register map and all five fields can be reached directly. The bench sweeps every BCD second against a single-field alarm and every hour against a three-field alarm. It also sweeps every weekday code, including the one above 6, to expose the per-field compare widths. It then steps through the flag's set, hold and clear cases, including a clear and a match on the same edge, while it checks the interrupt line against the enable.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int VAL_W      = 7;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_MDAY = 3'd3,
    FLD_WDAY = 3'd4
  } field_e;

  // bits of each field that take part in the compare
  function automatic logic [VAL_W-1:0] field_mask(input int idx);
    case (idx)
      FLD_SEC, FLD_MIN:   return 7'h7F;
      FLD_HOUR, FLD_MDAY: return 7'h3F;
      default:            return 7'h07;
    endcase
  endfunction
endpackage

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h0B
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0] regs_o
);
  localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(1) << (DATA_W-1);

  logic [NUM_FIELDS-1:0] sel;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    assign sel[g] = wr_en_i && (wr_addr_i == ADDR_W'(BASE + g));

    always_ff @(posedge clk) begin
      if (rst)         regs_o[g] <= RST_VAL;
      else if (sel[g]) regs_o[g] <= wr_data_i;
    end

    // R2
    wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
      sel[g] |=> regs_o[g] == $past(wr_data_i));
  end

  // R2
  one_sel_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(sel));
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              tick_i,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] regs_i,
  input  logic [NUM_FIELDS-1:0][VAL_W-1:0]  now_i,
  output logic                              hit_o
);
  localparam int OFF_BIT = DATA_W - 1;

  logic [NUM_FIELDS-1:0] used, agree;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    localparam logic [VAL_W-1:0] MSK = field_mask(g);
    assign used[g]  = ~regs_i[g][OFF_BIT];
    assign agree[g] = ~used[g] |
                      ((regs_i[g][VAL_W-1:0] & MSK) == (now_i[g] & MSK));
  end

  assign hit_o = tick_i & (|used) & (&agree);

  // R5
  hit_tick_chk: assert property (@(posedge clk) disable iff (rst) hit_o |-> tick_i);
  // R6
  hit_used_chk: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $countones(used) > 0);
endmodule

// File: rtl/alm_flag.sv
module alm_flag #(
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 6,
  parameter int AIE_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              hit_i,
  output logic              flag_o,
  output logic              aie_o,
  output logic              irq_n_o
);
  logic flag_d, aie_d;

  always_comb begin
    flag_d = flag_o;
    aie_d  = aie_o;
    if (ctrl_wr_i) begin
      aie_d = wr_data_i[AIE_BIT];
      if (!wr_data_i[FLAG_BIT]) flag_d = 1'b0;
    end
    if (hit_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= 1'b0;
      aie_o   <= 1'b0;
      irq_n_o <= 1'b1;
    end else begin
      flag_o  <= flag_d;
      aie_o   <= aie_d;
      irq_n_o <= ~(flag_d & aie_d);
    end
  end

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(hit_i));
  // R7
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !(ctrl_wr_i && !wr_data_i[FLAG_BIT])) |=> flag_o);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> flag_o);
  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n_o == !(flag_o && aie_o));
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] ALM_BASE  = 8'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              tick_i,
  input  logic [6:0]        sec_i,
  input  logic [6:0]        min_i,
  input  logic [5:0]        hour_i,
  input  logic [5:0]        mday_i,
  input  logic [2:0]        wday_i,
  output logic              alarm_flag_o,
  output logic              irq_n_o
);
  localparam int AIE_BIT  = DATA_W - 1;
  localparam int FLAG_BIT = DATA_W - 2;

  logic [NUM_FIELDS-1:0][DATA_W-1:0] alm_regs_q;
  logic [NUM_FIELDS-1:0][VAL_W-1:0]  now;
  logic                              hit, aie, ctrl_wr;
  logic [DATA_W-1:0]                 rd_d;

  assign now[FLD_SEC]  = VAL_W'(sec_i);
  assign now[FLD_MIN]  = VAL_W'(min_i);
  assign now[FLD_HOUR] = VAL_W'(hour_i);
  assign now[FLD_MDAY] = VAL_W'(mday_i);
  assign now[FLD_WDAY] = VAL_W'(wday_i);

  assign ctrl_wr = wr_en_i && (wr_addr_i == CTRL_ADDR);

  alm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(ALM_BASE)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .regs_o(alm_regs_q));

  alm_match #(.DATA_W(DATA_W)) u_match (
    .clk(clk), .rst(rst), .tick_i(tick_i), .regs_i(alm_regs_q),
    .now_i(now), .hit_o(hit));

  alm_flag #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT), .AIE_BIT(AIE_BIT)) u_flag (
    .clk(clk), .rst(rst), .ctrl_wr_i(ctrl_wr), .wr_data_i(wr_data_i),
    .hit_i(hit), .flag_o(alarm_flag_o), .aie_o(aie), .irq_n_o(irq_n_o));

  always_comb begin
    rd_d = '0;
    if (rd_addr_i == CTRL_ADDR) begin
      rd_d[AIE_BIT]  = aie;
      rd_d[FLAG_BIT] = alarm_flag_o;
    end
    for (int i = 0; i < NUM_FIELDS; i++)
      if (rd_addr_i == ADDR_W'(ALM_BASE + i)) rd_d = alm_regs_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_d;
  end

  // R10
  aie_wr_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> aie == $past(wr_data_i[AIE_BIT]));
endmodule

// File: tb/tb_alarm_cmp.sv
`timescale 1ns/1ps
module tb_alarm_cmp;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, tick = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0, rd_data;
  logic [6:0] sec = 0, mnt = 0;
  logic [5:0] hour = 0, mday = 0;
  logic [2:0] wday = 0;
  logic flag, irq_n;
  int checks = 0, errors = 0;
  logic [7:0] am [5];
  logic m_flag = 0, m_aie = 0;
  localparam logic [6:0] MK [5] = '{7'h7F, 7'h7F, 7'h3F, 7'h3F, 7'h07};

  always #2.5 clk = ~clk;

  alarm_cmp dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .tick_i(tick), .sec_i(sec), .min_i(mnt),
    .hour_i(hour), .mday_i(mday), .wday_i(wday), .alarm_flag_o(flag), .irq_n_o(irq_n));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic bit exp_match();
    logic [6:0] nv [5];
    bit any = 0, all = 1;
    nv[0] = sec; nv[1] = mnt; nv[2] = 7'(hour); nv[3] = 7'(mday); nv[4] = 7'(wday);
    for (int i = 0; i < 5; i++)
      if (!am[i][7]) begin
        any = 1;
        if ((am[i][6:0] & MK[i]) != (nv[i] & MK[i])) all = 0;
      end
    return any && all;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
    if (a == 8'h01) begin m_aie = d[7]; if (!d[6]) m_flag = 0; end
    else if (a >= 8'h0B && a <= 8'h0F) am[a - 8'h0B] = d;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); rd_addr = a;
    @(negedge clk); chk(req, rd_data, exp);
  endtask

  task automatic set_now(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                         input logic [5:0] d, input logic [2:0] w);
    sec = s; mnt = m; hour = h; mday = d; wday = w;
  endtask

  task automatic pulse(input string req);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    if (exp_match()) m_flag = 1;
    chk(req, flag, m_flag);
    chk("R9", irq_n, !(m_flag && m_aie));
  endtask

  task automatic clear_flag();
    wr(8'h01, {m_aie, 7'h00});
  endtask

  initial begin
    for (int i = 0; i < 5; i++) am[i] = 8'h80;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", flag, 0); chk("R1", irq_n, 1);
    for (int i = 0; i < 5; i++) rd_chk("R1", 8'(8'h0B + i), 8'h80);
    rd_chk("R1", 8'h01, 8'h00);

    // R6 all fields excluded: sweep seconds, never a flag
    for (int s = 0; s < 60; s++) begin set_now(7'(bcd(s)), 7'h00, 6'h00, 6'h01, 3'd0); pulse("R6"); end

    // R3/R4 second only; minute excluded with a different value
    wr(8'h0B, 8'h25); wr(8'h0C, 8'h91);
    for (int s = 0; s < 60; s++) begin
      set_now(7'(bcd(s)), 7'h33, 6'h07, 6'h15, 3'd2); pulse("R4");
      if (m_flag) clear_flag();
    end

    // R4 three fields: second, minute, hour
    wr(8'h0B, 8'h30); wr(8'h0C, 8'h45); wr(8'h0D, 8'h12);
    for (int h = 0; h < 24; h++)
      for (int k = 0; k < 4; k++) begin
        set_now(k[0] ? 7'h31 : 7'h30, k[1] ? 7'h44 : 7'h45, 6'(bcd(h)), 6'h09, 3'd4);
        pulse("R4");
        if (m_flag) clear_flag();
      end

    // R3 compare widths: weekday 3 bits (0x7B -> 3), day 6 bits (0x45 -> 05)
    wr(8'h0B, 8'h80); wr(8'h0C, 8'h80); wr(8'h0D, 8'h80);
    wr(8'h0E, 8'h45); wr(8'h0F, 8'h7B);
    for (int w = 0; w < 8; w++) begin
      set_now(7'h00, 7'h00, 6'h00, 6'h05, 3'(w)); pulse("R3");
      if (m_flag) clear_flag();
    end
    set_now(7'h00, 7'h00, 6'h00, 6'h06, 3'd3); pulse("R3");

    // R5 matching calendar without the pulse
    set_now(7'h00, 7'h00, 6'h00, 6'h05, 3'd3);
    repeat (5) @(negedge clk);
    chk("R5", flag, 0);

    // R7/R9/R10 sticky flag and interrupt
    pulse("R4");
    chk("R9", irq_n, 1);
    wr(8'h01, 8'hC0);
    chk("R7", flag, 1); chk("R9", irq_n, 0);
    rd_chk("R10", 8'h01, 8'hC0);
    set_now(7'h00, 7'h00, 6'h00, 6'h06, 3'd1); pulse("R7");
    wr(8'h01, 8'hFF);
    rd_chk("R2", 8'h01, 8'hC0);
    wr(8'h01, 8'h80);
    chk("R7", flag, 0); chk("R9", irq_n, 1);
    rd_chk("R10", 8'h01, 8'h80);

    // R8 clear and match on the same edge
    set_now(7'h00, 7'h00, 6'h00, 6'h05, 3'd3);
    @(negedge clk); wr_en = 1; wr_addr = 8'h01; wr_data = 8'h80; tick = 1;
    @(negedge clk); wr_en = 0; tick = 0; m_flag = 1;
    chk("R8", flag, 1); chk("R9", irq_n, 0);
    clear_flag();

    // R2 readback of the map
    wr(8'h0B, 8'h59); wr(8'h0C, 8'hA7); wr(8'h0D, 8'h23); wr(8'h0E, 8'hF1); wr(8'h0F, 8'h06);
    for (int i = 0; i < 5; i++) rd_chk("R2", 8'(8'h0B + i), am[i]);
    wr(8'h05, 8'h3C);
    rd_chk("R2", 8'h05, 8'h00);
    rd_chk("R2", 8'h10, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule